// File: doc/BRIEF.md
# IRQ/FIQ Interrupt Controller

This block gathers 32 level-sensitive interrupt sources into a sticky pending register. A per-source enable mask decides whether a pending source may interrupt the processor. A per-source routing register then sends the enabled source either to the normal interrupt line (`irq_o`) or to the fast interrupt line (`fiq_o`). Each line stays high while at least one source is routed to it.

Software reaches the block through a simple word-wide register port. A request with `we_i` low is a read. Its data comes back one cycle later together with a single-cycle `rvalid_o` strobe. Software can read the raw pending word and the two routed views, and can also overwrite the raw pending word directly. Writing the mask has two effects: it loads the mask, and it clears the pending bit of every source whose data bit is 1. Sources are wired by convention: bit 31 is the calendar alarm, bit 30 is the calendar tick, bits 29..26 are timer compares 3..0, and bit 22 is the serial port. The block itself treats every source the same way.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset the mask, routing, raw pending and control registers read 0, and `irq_o` and `fiq_o` are low.
- R2: Offset 0x00 reads mask & pending & ~routing. `irq_o` is high exactly while that word is nonzero.
- R3: Offset 0x0C reads mask & pending & routing. `fiq_o` is high exactly while that word is nonzero. A routing bit of 1 selects the fast line.
- R4: Every source bit that is high at a clock edge sets its pending bit at that edge. The bit stays set after the source drops, and offset 0x10 reads the raw pending word.
- R5: A write to offset 0x04 loads the mask and clears each pending bit whose written data bit is 1.
- R6: A write to offset 0x10 loads the raw pending word. A source that is high in the same cycle keeps its pending bit set, and this also holds during a clearing mask write.
- R7: Writes to offsets 0x00 and 0x0C, and to any unmapped offset, change no state. Reads of unmapped offsets return 0.
- R8: A read request returns its data with `rvalid_o` high for exactly one cycle, in the cycle after the request. The data is the register state from before that edge. Writes never raise `rvalid_o`.
- R9: Offset 0x08 holds the routing word as written. Offset 0x14 keeps only data bit 0, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt sources |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while `rvalid_o` is high |
| rvalid_o | output | 1 | Read data strobe |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The assertions check the following on every cycle:
- a high source always shows up in pending on the next cycle;
- a mask write leaves the mask equal to the data and no cleared bit set unless its source was high;
- writes to the view offsets leave mask and routing untouched;
- the read strobe follows exactly one cycle after each read;
- an empty mask silences both lines, and all-fast routing silences `irq_o`.

Only the bench scenarios show the following:
- the exact contents of the two views as mask, routing and pending change;
- that a source wins over both kinds of software clear;
- that pending stays set once a source drops;
- the truncation of the control word;
- that unmapped offsets read zero.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
package ifc_pkg;
  localparam int unsigned OFS_IRQ_VIEW = 'h00;
  localparam int unsigned OFS_MASK     = 'h04;
  localparam int unsigned OFS_ROUTE    = 'h08;
  localparam int unsigned OFS_FIQ_VIEW = 'h0C;
  localparam int unsigned OFS_RAW      = 'h10;
  localparam int unsigned OFS_CTRL     = 'h14;

  // conventional source positions
  localparam int unsigned SRC_CAL_ALARM = 31;
  localparam int unsigned SRC_CAL_TICK  = 30;
  localparam int unsigned SRC_TMR_HI    = 29;
  localparam int unsigned SRC_TMR_LO    = 26;
  localparam int unsigned SRC_SERIAL    = 22;

  localparam int unsigned CTRL_W = 1;

  typedef enum logic [2:0] {
    SEL_IRQ_VIEW, SEL_MASK, SEL_ROUTE, SEL_FIQ_VIEW, SEL_RAW, SEL_CTRL, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/ifc_pending.sv
`timescale 1ns/1ps
module ifc_pending #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_raw_i,
  input  logic            wr_clr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic q, d;
    always_comb begin
      if (wr_raw_i)                  d = wdata_i[i];
      else if (wr_clr_i && wdata_i[i]) d = 1'b0;
      else                           d = q;
      d = d | src_i[i];  // live source beats any software clear
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d;
    end
    assign pend_o[i] = q;
  end
endmodule

// File: rtl/ifc_steer.sv
`timescale 1ns/1ps
module ifc_steer #(
  parameter int unsigned NSRC = 32
) (
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] route_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] irq_view_o,
  output logic [NSRC-1:0] fiq_view_o,
  output logic            irq_o,
  output logic            fiq_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic live;
    assign live          = mask_i[i] & pend_i[i];
    assign irq_view_o[i] = live & ~route_i[i];
    assign fiq_view_o[i] = live &  route_i[i];
  end
  assign irq_o = |irq_view_o;
  assign fiq_o = |fiq_view_o;
endmodule

// File: rtl/ifc_csr.sv
`timescale 1ns/1ps
module ifc_csr
  import ifc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pend_i,
  input  logic [DW-1:0] irq_view_i,
  input  logic [DW-1:0] fiq_view_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] route_o,
  output logic          wr_raw_o,
  output logic          wr_clr_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  reg_sel_e          sel;
  logic              wr, rd;
  logic [DW-1:0]     mask_q, route_q, rd_mux;
  logic [CTRL_W-1:0] ctrl_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    if      (addr_i == AW'(OFS_IRQ_VIEW)) sel = SEL_IRQ_VIEW;
    else if (addr_i == AW'(OFS_MASK))     sel = SEL_MASK;
    else if (addr_i == AW'(OFS_ROUTE))    sel = SEL_ROUTE;
    else if (addr_i == AW'(OFS_FIQ_VIEW)) sel = SEL_FIQ_VIEW;
    else if (addr_i == AW'(OFS_RAW))      sel = SEL_RAW;
    else if (addr_i == AW'(OFS_CTRL))     sel = SEL_CTRL;
    else                                  sel = SEL_NONE;
  end

  assign wr_raw_o = wr && (sel == SEL_RAW);
  assign wr_clr_o = wr && (sel == SEL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
      ctrl_q  <= '0;
    end else if (wr) begin
      if (sel == SEL_MASK)  mask_q  <= wdata_i;
      if (sel == SEL_ROUTE) route_q <= wdata_i;
      if (sel == SEL_CTRL)  ctrl_q  <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_IRQ_VIEW: rd_mux = irq_view_i;
      SEL_MASK:     rd_mux = mask_q;
      SEL_ROUTE:    rd_mux = route_q;
      SEL_FIQ_VIEW: rd_mux = fiq_view_i;
      SEL_RAW:      rd_mux = pend_i;
      SEL_CTRL:     rd_mux = DW'(ctrl_q);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_fiq_ctrl.sv
`timescale 1ns/1ps
module irq_fiq_ctrl #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          irq_o,
  output logic          fiq_o
);
  logic [DW-1:0] mask_q, level_q, pend_q, irq_view, fiq_view;
  logic          wr_raw, wr_clr;

  ifc_csr #(.AW(AW), .DW(DW)) u_csr (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .pend_i(pend_q), .irq_view_i(irq_view), .fiq_view_i(fiq_view),
    .mask_o(mask_q), .route_o(level_q), .wr_raw_o(wr_raw), .wr_clr_o(wr_clr),
    .rdata_o, .rvalid_o
  );

  ifc_pending #(.NSRC(DW)) u_pend (
    .clk_i, .rst_ni, .src_i, .wr_raw_i(wr_raw), .wr_clr_i(wr_clr),
    .wdata_i, .pend_o(pend_q)
  );

  ifc_steer #(.NSRC(DW)) u_steer (
    .mask_i(mask_q), .route_i(level_q), .pend_i(pend_q),
    .irq_view_o(irq_view), .fiq_view_o(fiq_view), .irq_o, .fiq_o
  );
endmodule

// File: rtl/irq_fiq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_chk
  import ifc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] src_i,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          rvalid_o,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] level_q,
  input logic [DW-1:0] pend_q
);
  p_quiet_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (!irq_o && !fiq_o));

  p_all_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == '1) |-> !irq_o);

  p_src_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((pend_q & $past(src_i)) == $past(src_i)));

  p_mask_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(OFS_MASK)) |=>
      (mask_q == $past(wdata_i)) && ((pend_q & $past(wdata_i) & ~$past(src_i)) == '0));

  p_view_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i == AW'(OFS_IRQ_VIEW) || addr_i == AW'(OFS_FIQ_VIEW))) |=>
      ($stable(mask_q) && $stable(level_q)));

  p_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_no_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .irq_o(irq_o),
  .fiq_o(fiq_o), .mask_q(mask_q), .level_q(level_q), .pend_q(pend_q)
);

// File: tb/irq_fiq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  irq_fiq_ctrl dut_i (
    .clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o, .irq_o, .fiq_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] s = '0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; src_i = s;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; src_i = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic pulse(logic [31:0] s);
    @(negedge clk_i); src_i = s;
    @(negedge clk_i); src_i = '0;
  endtask

  task automatic pins(string tag, logic ei, logic ef);
    check({tag, " irq_o"}, {31'b0, irq_o}, {31'b0, ei});
    check({tag, " fiq_o"}, {31'b0, fiq_o}, {31'b0, ef});
  endtask

  // scoreboard monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected rvalid_o data %08h expected none", rdata_o);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata_o, e);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    pins("R1 reset", 1'b0, 1'b0);
    rd(8'h04, 32'h0, "R1 mask");
    rd(8'h08, 32'h0, "R1 level");
    rd(8'h10, 32'h0, "R1 raw");
    rd(8'h14, 32'h0, "R1 ctrl");
    rd(8'h00, 32'h0, "R1 irq view");
    rd(8'h0C, 32'h0, "R1 fiq view");

    // sticky capture, masked
    pulse(32'h8000_0001);
    @(negedge clk_i);
    rd(8'h10, 32'h8000_0001, "R4 sticky raw");
    pins("R2 masked", 1'b0, 1'b0);

    // routing and mask write clears
    wr(8'h08, 32'h8000_0000);
    wr(8'h04, 32'hC000_0003);
    rd(8'h10, 32'h0, "R5 mask clears pending");
    rd(8'h04, 32'hC000_0003, "R5 mask load");
    rd(8'h08, 32'h8000_0000, "R9 level");
    pins("R5 after clear", 1'b0, 1'b0);

    pulse(32'h8000_0001);
    pins("R2/R3 split", 1'b1, 1'b1);
    rd(8'h00, 32'h0000_0001, "R2 irq view");
    rd(8'h0C, 32'h8000_0000, "R3 fiq view");

    // raw write
    wr(8'h10, 32'h4000_0000);
    pins("R6 raw load", 1'b1, 1'b0);
    rd(8'h00, 32'h4000_0000, "R6 irq view after raw");
    rd(8'h10, 32'h4000_0000, "R6 raw readback");

    // source beats raw clear
    wr(8'h10, 32'h0, 32'h0000_0002);
    rd(8'h10, 32'h0000_0002, "R6 source wins raw write");
    pins("R6 bit1 live", 1'b1, 1'b0);

    // source beats mask clear
    wr(8'h04, 32'h0000_0002, 32'h0000_0002);
    rd(8'h10, 32'h0000_0002, "R6 source wins mask clear");
    rd(8'h00, 32'h0000_0002, "R2 irq view bit1");

    // ignored writes
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_0002, "R7 mask kept");
    rd(8'h08, 32'h8000_0000, "R7 level kept");
    rd(8'h10, 32'h0000_0002, "R7 raw kept");
    rd(8'h18, 32'h0, "R7 unmapped read");
    rd(8'h40, 32'h0, "R7 unmapped read far");

    // control width
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h0000_0001, "R9 ctrl bit0 only");

    // all fast
    wr(8'h08, 32'hFFFF_FFFF);
    pins("R3 all fast", 1'b0, 1'b1);
    rd(8'h0C, 32'h0000_0002, "R3 fiq view bit1");
    rd(8'h00, 32'h0, "R2 irq view empty");

    repeat (3) @(negedge clk_i);
    check("R8 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule